// File: doc/BRIEF.md
# Pixel Array Readout and Global Sum Unit

This unit is the output path at the edge of a pixel-parallel processing array. Every pixel has an 8-bit grey value and a 1-bit binary value. A single 8-bit output port delivers the result of one of five readout modes, one byte per cycle, and a valid strobe marks each byte. The modes are:

- one addressed grey pixel;
- eight neighbouring binary pixels packed into a byte;
- the sum of all grey values over the frame;
- the coordinates of every set binary pixel, streamed as address events;
- the OR of the binary values over a selected group of pixels.

A group is a single address, an inclusive rectangle or a free per-pixel mask.

The host sets the mode, the address fields and the mask, then pulses `start` while `busy` is low. On acceptance the unit copies the whole array into its own register array, so the array may change while the readout runs. For the frame sum, each row is added by a west-to-east chain of cells. The result of that chain appears at the east end of the row. The row results are then added at the periphery into a dedicated sum register, and that register is streamed out. A one-cycle `done` pulse closes every operation.

Top module: `arr_readout`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `done` and `busy` are low until a start is accepted.
- R2: Mode code 0 emits one byte: the grey value of the pixel at column `x0`, row `y0`. The flat pixel index is `y0*COLS + x0`, and pixel i occupies bits `[8i+7:8i]` of `pix_grey`.
- R3: Mode code 1 emits one byte. Bit i holds the binary value of the pixel at column `x0+i` in row `y0`, where `pix_bin` bit `y*COLS+x` holds pixel (x,y). A bit whose column lies past the east edge reads 0.
- R4: Mode code 2 emits the sum of all grey values as `SUM_BYTES` bytes, least significant byte first. The sum register is wide enough that the all-255 frame (255*ROWS*COLS) is exact.
- R5: Mode code 3 scans the pixels in raster order: row 0 first, and within each row from column 0 eastward. For each set binary pixel it emits its column byte, then its row byte. A frame with no set pixel emits no bytes.
- R6: Mode code 4 emits one byte, `{7'b0, or}`, where `or` is the OR of the binary values of the selected pixels. The group comes from `sel_kind`: 0 selects pixel (`x0`,`y0`); 1 selects the rectangle spanning columns `x0` to `x1` and rows `y0` to `y1`, inclusive, which is empty when `x1<x0` or `y1<y0`; 2 selects the pixels whose `pattern` bit (index `y*COLS+x`) is set; 3 selects nothing.
- R7: `done` is high for exactly one cycle, in the cycle after the last byte, or after the scan ends when no byte is emitted. `out_valid` and `busy` are low in that cycle.
- R8: A start is taken only when `busy` is low and the mode code is in the range 0 to 4. Each of the following has no effect on the current or any later output: a start while busy, a start with codes 5 to 7, and changes to the mode, the address fields, the mask or the array data after acceptance.
- R9: `out_valid` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a readout |
| mode | input | 3 | Readout mode code, 0 to 4 |
| sel_kind | input | 2 | Group kind for the OR mode |
| x0 | input | XW | Column address, or first column of a rectangle |
| y0 | input | YW | Row address, or first row of a rectangle |
| x1 | input | XW | Last column of a rectangle |
| y1 | input | YW | Last row of a rectangle |
| pattern | input | ROWS*COLS | Per-pixel selection mask |
| pix_grey | input | ROWS*COLS*8 | Grey values of the array |
| pix_bin | input | ROWS*COLS | Binary values of the array |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | Marks a valid output byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| busy | output | 1 | An operation is in progress |

## Verification
The assertions assume that the host raises `start` only with a legal mode code when it expects a new operation. They also assume the addresses lie inside the array, and the bench draws every address inside the array. The bench pulses `start` for one cycle at a time. In about half of the operations it also pulses `start` again during the busy period, together with a random mode, new addresses and a new array. This checks that the stream still matches the values captured at acceptance. Random binary frames are drawn at several densities so that both sparse and dense address-event streams occur.

// File: rtl/arr_ro_pkg.sv
// Package: shared codes for the array readout unit.
// Assumes: mode codes above RO_OR are illegal and are ignored by the unit.
package arr_ro_pkg;
    typedef enum logic [2:0] {
        RO_GREY = 3'd0,
        RO_BIN8 = 3'd1,
        RO_SUM  = 3'd2,
        RO_AER  = 3'd3,
        RO_OR   = 3'd4
    } ro_mode_e;

    typedef enum logic [1:0] {
        SEL_ONE  = 2'd0,
        SEL_RECT = 2'd1,
        SEL_PAT  = 2'd2,
        SEL_NONE = 2'd3
    } sel_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ONE,
        ST_SUMLD,
        ST_SUMB,
        ST_SCAN,
        ST_AERY,
        ST_FIN
    } ro_state_e;
endpackage

// File: rtl/rowsum_cell.sv
// Module: one cell of a row adder chain.
// Takes the partial sum from its west neighbour, adds its own grey value
// and passes the result to its east neighbour.
// Assumes: SW is at least 8 and wide enough for a whole row.
module rowsum_cell #(
    parameter int SW = 13
) (
    input  logic [SW-1:0] west_in,
    input  logic [7:0]    px,
    output logic [SW-1:0] east_out
);
    // Add this cell's value onto the incoming partial sum.
    always_comb east_out = west_in + SW'(px);
endmodule

// File: rtl/rowsum_chain.sv
// Module: west-to-east adder chain across one row of cells.
// The row result appears at the east end of the chain.
// Assumes: row_px holds column c in bits [8c+7:8c].
module rowsum_chain #(
    parameter int COLS = 8,
    parameter int SW   = 13
) (
    input  logic [COLS*8-1:0] row_px,
    output logic [SW-1:0]     east_sum
);
    logic [SW-1:0] link [COLS+1];

    assign link[0] = '0;

    for (genvar c = 0; c < COLS; c++) begin : g_cell
        rowsum_cell #(.SW(SW)) cell_i (
            .west_in  (link[c]),
            .px       (row_px[c*8 +: 8]),
            .east_out (link[c+1])
        );
    end

    assign east_sum = link[COLS];
endmodule

// File: rtl/sel_mask.sv
// Module: builds the per-pixel selection mask for the OR reduction.
// Kinds: a single address, an inclusive rectangle, a free mask, or nothing.
// Assumes: bit y*COLS+x of the mask belongs to pixel (x,y).
module sel_mask
    import arr_ro_pkg::*;
#(
    parameter int COLS = 8,
    parameter int ROWS = 4,
    parameter int XW   = 3,
    parameter int YW   = 2
) (
    input  logic [1:0]         kind,
    input  logic [XW-1:0]      x0,
    input  logic [YW-1:0]      y0,
    input  logic [XW-1:0]      x1,
    input  logic [YW-1:0]      y1,
    input  logic [ROWS*COLS-1:0] pattern,
    output logic [ROWS*COLS-1:0] mask
);
    for (genvar gy = 0; gy < ROWS; gy++) begin : g_row
        for (genvar gx = 0; gx < COLS; gx++) begin : g_col
            localparam logic [XW-1:0] XC = XW'(gx);
            localparam logic [YW-1:0] YC = YW'(gy);
            // Decide whether pixel (gx,gy) belongs to the group.
            always_comb begin
                unique case (sel_kind_e'(kind))
                    SEL_ONE:  mask[gy*COLS+gx] = (x0 == XC) && (y0 == YC);
                    SEL_RECT: mask[gy*COLS+gx] = (XC >= x0) && (XC <= x1) &&
                                                 (YC >= y0) && (YC <= y1);
                    SEL_PAT:  mask[gy*COLS+gx] = pattern[gy*COLS+gx];
                    default:  mask[gy*COLS+gx] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/arr_readout.sv
// Module: readout unit for a pixel array, with one byte output port.
// Modes: one grey pixel, eight packed binary pixels, the global grey sum
// (row chains plus a periphery adder into a sum register), an address-event
// coordinate stream, and an OR over a selected group of pixels.
// Assumes: COLS and ROWS are each at most 256, addresses lie inside the
// array, and start is honoured only while idle with a legal mode code.
module arr_readout
    import arr_ro_pkg::*;
#(
    parameter int COLS = 8,
    parameter int ROWS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [2:0]             mode,
    input  logic [1:0]             sel_kind,
    input  logic [((COLS>1)?$clog2(COLS):1)-1:0] x0,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] y0,
    input  logic [((COLS>1)?$clog2(COLS):1)-1:0] x1,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] y1,
    input  logic [ROWS*COLS-1:0]   pattern,
    input  logic [ROWS*COLS*8-1:0] pix_grey,
    input  logic [ROWS*COLS-1:0]   pix_bin,
    output logic [7:0]             out_byte,
    output logic                   out_valid,
    output logic                   done,
    output logic                   busy
);
    localparam int N         = ROWS * COLS;
    localparam int XW        = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int YW        = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int MAXSUM    = 255 * N;
    localparam int SW        = $clog2(MAXSUM + 1);
    localparam int SUM_BYTES = (SW + 7) / 8;
    localparam int SBW       = (SUM_BYTES > 1) ? $clog2(SUM_BYTES) : 1;

    ro_state_e           state_q;
    logic [N*8-1:0]      grey_q;
    logic [N-1:0]        bin_q;
    logic [N-1:0]        pat_q;
    ro_mode_e            mode_q;
    logic [1:0]          kind_q;
    logic [XW-1:0]       x0_q, x1_q, sx_q;
    logic [YW-1:0]       y0_q, y1_q, sy_q;
    logic [SW-1:0]       sum_q;
    logic [SBW-1:0]      bidx_q;

    logic                accept;
    logic [7:0]          grey_sel;
    logic [7:0]          bin8_sel;
    logic [N-1:0]        mask;
    logic                or_bit;
    logic [SW-1:0]       row_sum [ROWS];
    logic [SW-1:0]       total;
    logic [SUM_BYTES*8-1:0] sum_ext;
    logic                scan_set;
    logic                scan_last;

    // Accept a new operation only from idle with a legal mode code.
    always_comb accept = start && (state_q == ST_IDLE) && (mode <= 3'd4);

    // Pick the addressed grey pixel from the captured frame.
    always_comb begin
        int pidx;
        pidx     = int'(y0_q) * COLS + int'(x0_q);
        grey_sel = grey_q[pidx*8 +: 8];
    end

    // Pack eight binary pixels eastward from the address; past the edge reads 0.
    always_comb begin
        bin8_sel = '0;
        for (int i = 0; i < 8; i++) begin
            int xi;
            xi = int'(x0_q) + i;
            if (xi < COLS) bin8_sel[i] = bin_q[int'(y0_q) * COLS + xi];
        end
    end

    sel_mask #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) mask_i (
        .kind    (kind_q),
        .x0      (x0_q),
        .y0      (y0_q),
        .x1      (x1_q),
        .y1      (y1_q),
        .pattern (pat_q),
        .mask    (mask)
    );

    // Reduce the selected binary pixels to a single OR bit.
    always_comb or_bit = |(bin_q & mask);

    for (genvar r = 0; r < ROWS; r++) begin : g_rows
        rowsum_chain #(.COLS(COLS), .SW(SW)) chain_i (
            .row_px   (grey_q[r*COLS*8 +: COLS*8]),
            .east_sum (row_sum[r])
        );
    end

    // Add the row results at the periphery.
    always_comb begin
        total = '0;
        for (int r = 0; r < ROWS; r++) total = total + row_sum[r];
    end

    // Widen the sum register to whole bytes for readout.
    always_comb sum_ext = (SUM_BYTES*8)'(sum_q);

    // Look at the captured binary bit under the scan position.
    always_comb begin
        scan_set  = bin_q[int'(sy_q) * COLS + int'(sx_q)];
        scan_last = (sx_q == XW'(COLS - 1)) && (sy_q == YW'(ROWS - 1));
    end

    // Main sequencer: capture on accept, then stream bytes and close with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            grey_q    <= '0;
            bin_q     <= '0;
            pat_q     <= '0;
            mode_q    <= RO_GREY;
            kind_q    <= '0;
            x0_q      <= '0;
            x1_q      <= '0;
            y0_q      <= '0;
            y1_q      <= '0;
            sx_q      <= '0;
            sy_q      <= '0;
            sum_q     <= '0;
            bidx_q    <= '0;
            out_byte  <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        grey_q <= pix_grey;
                        bin_q  <= pix_bin;
                        pat_q  <= pattern;
                        mode_q <= ro_mode_e'(mode);
                        kind_q <= sel_kind;
                        x0_q   <= x0;
                        x1_q   <= x1;
                        y0_q   <= y0;
                        y1_q   <= y1;
                        sx_q   <= '0;
                        sy_q   <= '0;
                        bidx_q <= '0;
                        unique case (ro_mode_e'(mode))
                            RO_SUM:  state_q <= ST_SUMLD;
                            RO_AER:  state_q <= ST_SCAN;
                            default: state_q <= ST_ONE;
                        endcase
                    end
                end
                ST_ONE: begin
                    out_valid <= 1'b1;
                    unique case (mode_q)
                        RO_GREY: out_byte <= grey_sel;
                        RO_BIN8: out_byte <= bin8_sel;
                        default: out_byte <= {7'b0, or_bit};
                    endcase
                    state_q <= ST_FIN;
                end
                ST_SUMLD: begin
                    sum_q   <= total;
                    state_q <= ST_SUMB;
                end
                ST_SUMB: begin
                    out_valid <= 1'b1;
                    out_byte  <= sum_ext[bidx_q*8 +: 8];
                    bidx_q    <= bidx_q + 1'b1;
                    if (int'(bidx_q) == SUM_BYTES - 1) state_q <= ST_FIN;
                end
                ST_SCAN: begin
                    if (scan_set) begin
                        out_valid <= 1'b1;
                        out_byte  <= 8'(sx_q);
                        state_q   <= ST_AERY;
                    end else if (scan_last) begin
                        state_q <= ST_FIN;
                    end else if (sx_q == XW'(COLS - 1)) begin
                        sx_q <= '0;
                        sy_q <= sy_q + 1'b1;
                    end else begin
                        sx_q <= sx_q + 1'b1;
                    end
                end
                ST_AERY: begin
                    out_valid <= 1'b1;
                    out_byte  <= 8'(sy_q);
                    if (scan_last) begin
                        state_q <= ST_FIN;
                    end else begin
                        state_q <= ST_SCAN;
                        if (sx_q == XW'(COLS - 1)) begin
                            sx_q <= '0;
                            sy_q <= sy_q + 1'b1;
                        end else begin
                            sx_q <= sx_q + 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Report activity to the host.
    always_comb busy = (state_q != ST_IDLE);
endmodule

// File: rtl/arr_readout_chk.sv
// Module: protocol checker for arr_readout, attached by bind.
// Assumes: synchronous active-low reset on the same clock.
module arr_readout_chk #(
    parameter int SW     = 13,
    parameter int MAXSUM = 8160
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    mode,
    input logic          out_valid,
    input logic          done,
    input logic          busy,
    input logic [SW-1:0] sum_q
);
    a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !out_valid));

    a_r8_legal_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && ($past(mode) <= 3'd4)));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sum_q) <= MAXSUM);
endmodule

bind arr_readout arr_readout_chk #(.SW(SW), .MAXSUM(MAXSUM)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .out_valid (out_valid),
    .done      (done),
    .busy      (busy),
    .sum_q     (sum_q)
);

// File: tb/arr_readout_tb_top.sv
module arr_readout_tb_top;
    localparam int C = 8;
    localparam int R = 4;
    localparam int N = C * R;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2:0]     mode = '0;
    logic [1:0]     kind = '0;
    logic [2:0]     x0 = '0, x1 = '0;
    logic [1:0]     y0 = '0, y1 = '0;
    logic [N-1:0]   pat = '0;
    logic [N*8-1:0] grey = '0;
    logic [N-1:0]   bin = '0;
    logic [7:0]     out_byte;
    logic           out_valid, done, busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];

    always #2.5 clk = ~clk;

    arr_readout #(.COLS(C), .ROWS(R)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sel_kind(kind),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1), .pattern(pat),
        .pix_grey(grey), .pix_bin(bin),
        .out_byte(out_byte), .out_valid(out_valid), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Expected byte stream computed from the requirements.
    task automatic build_exp();
        exp_q.delete();
        case (mode)
            3'd0: exp_q.push_back(grey[(int'(y0)*C + int'(x0))*8 +: 8]);
            3'd1: begin
                logic [7:0] b;
                b = '0;
                for (int i = 0; i < 8; i++)
                    if (int'(x0) + i < C) b[i] = bin[int'(y0)*C + int'(x0) + i];
                exp_q.push_back(b);
            end
            3'd2: begin
                int s;
                s = 0;
                for (int i = 0; i < N; i++) s += int'(grey[i*8 +: 8]);
                exp_q.push_back(s[7:0]);
                exp_q.push_back(s[15:8]);
            end
            3'd3: begin
                for (int yy = 0; yy < R; yy++)
                    for (int xx = 0; xx < C; xx++)
                        if (bin[yy*C + xx]) begin
                            exp_q.push_back(8'(xx));
                            exp_q.push_back(8'(yy));
                        end
            end
            default: begin
                bit o;
                o = 1'b0;
                for (int yy = 0; yy < R; yy++)
                    for (int xx = 0; xx < C; xx++) begin
                        bit s;
                        case (kind)
                            2'd0: s = (xx == int'(x0)) && (yy == int'(y0));
                            2'd1: s = (xx >= int'(x0)) && (xx <= int'(x1)) &&
                                      (yy >= int'(y0)) && (yy <= int'(y1));
                            2'd2: s = pat[yy*C + xx];
                            default: s = 1'b0;
                        endcase
                        if (s && bin[yy*C + xx]) o = 1'b1;
                    end
                exp_q.push_back({7'b0, o});
            end
        endcase
    endtask

    task automatic rand_frame(input int density);
        for (int i = 0; i < N; i++) begin
            grey[i*8 +: 8] = 8'($urandom);
            bin[i] = ($urandom % 100) < density;
        end
        pat = N'({$urandom, $urandom});
    endtask

    // Run one operation; optionally disturb all inputs while busy (R8).
    task automatic run_op(input bit disturb);
        bit fin;
        int k;
        string rq;
        rq = req_of(mode);
        build_exp();
        got_q.delete();
        @(negedge clk);
        start = 1'b1;
        fin = 1'b0;
        k = 0;
        while (!fin && k < 400) begin
            @(negedge clk);
            k++;
            if (out_valid) got_q.push_back(out_byte);
            if (out_valid && !busy) check(1'b0, "R9", "valid outside busy", 1, 0);
            if (done) begin
                fin = 1'b1;
                check(!busy && !out_valid, "R7", "done with busy/valid",
                      int'({busy, out_valid}), 0);
            end
            if (k == 1 && disturb) begin
                start = 1'b1;
                mode  = 3'($urandom);
                kind  = 2'($urandom);
                x0 = 3'($urandom); y0 = 2'($urandom);
                rand_frame(50);
            end else begin
                start = 1'b0;
            end
        end
        check(fin, rq, "done seen", int'(fin), 1);
        if (got_q.size() != exp_q.size()) begin
            check(1'b0, disturb ? {rq, "/R8"} : rq, "byte count",
                  got_q.size(), exp_q.size());
        end else begin
            bit ok;
            int bad;
            ok = 1'b1;
            bad = 0;
            for (int i = 0; i < exp_q.size(); i++)
                if (ok && got_q[i] !== exp_q[i]) begin ok = 1'b0; bad = i; end
            check(ok, disturb ? {rq, "/R8"} : rq, "stream byte",
                  ok ? 0 : int'(got_q[bad]), ok ? 0 : int'(exp_q[bad]));
        end
        // done then idle one more cycle: no stray byte after done
        @(negedge clk);
        check(!out_valid && !done, "R7", "quiet after done",
              int'({out_valid, done}), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(!out_valid && !done && !busy, "R1", "outputs in reset",
              int'({out_valid, done, busy}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !done && !busy, "R1", "outputs after reset",
              int'({out_valid, done, busy}), 0);

        // R2 last pixel
        rand_frame(30);
        mode = 3'd0; x0 = 3'd7; y0 = 2'd3;
        run_op(1'b0);
        // R3 east edge
        mode = 3'd1; x0 = 3'd5; y0 = 2'd2; bin = '1;
        run_op(1'b0);
        // R4 maximum total: 8160 -> E0 1F
        mode = 3'd2; grey = '1;
        run_op(1'b0);
        check(exp_q[0] == 8'hE0 && exp_q[1] == 8'h1F, "R4", "max sum model",
              int'({exp_q[1], exp_q[0]}), 16'h1FE0);
        // R4 zero frame
        grey = '0;
        run_op(1'b0);
        // R5 no set pixel, then all set
        mode = 3'd3; bin = '0;
        run_op(1'b0);
        bin = '1;
        run_op(1'b0);
        // R6 empty rectangle, nothing-kind, empty pattern
        mode = 3'd4; kind = 2'd1; x0 = 3'd5; x1 = 3'd2; y0 = 2'd0; y1 = 2'd3;
        run_op(1'b0);
        kind = 2'd3;
        run_op(1'b0);
        kind = 2'd2; pat = '0;
        run_op(1'b0);
        // R6 single pixel set inside rectangle
        bin = '0; bin[2*C + 4] = 1'b1;
        kind = 2'd1; x0 = 3'd3; x1 = 3'd4; y0 = 2'd1; y1 = 2'd2;
        run_op(1'b0);

        // R8 illegal mode codes are not accepted
        for (int m = 5; m < 8; m++) begin
            bit seen;
            seen = 1'b0;
            @(negedge clk);
            mode = 3'(m); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (6) begin
                if (busy || out_valid || done) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen, "R8", "illegal mode ignored", int'(seen), 0);
        end

        // Random mix with disturbance while busy
        for (int t = 0; t < 80; t++) begin
            int dens;
            dens = (t % 4 == 0) ? 5 : ((t % 4 == 1) ? 90 : 40);
            rand_frame(dens);
            mode = 3'($urandom % 5);
            kind = 2'($urandom);
            x0 = 3'($urandom); x1 = 3'($urandom);
            y0 = 2'($urandom); y1 = 2'($urandom);
            run_op(($urandom % 2) == 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule